// File: doc/BRIEF.md
# Merged-Level Logical Barrel Shifter

This block is a purely combinational logical shifter for a WIDTH-bit word. A shift amount of log2(WIDTH) bits moves the word toward the most significant end (left build) or toward the least significant end (right build). Vacated positions receive zeros and bits pushed past the edge are lost. The direction is fixed per instance by a parameter.

The shifter is not built as one 2:1 multiplexer level per shift-amount bit. Shift-amount bits are grouped into levels of one, two or three bits. A two-bit level is a 4:1 multiplexer over four constant-offset copies of its input. A three-bit level is an 8:1 multiplexer over eight copies. The grouping is computed at elaboration time from a per-bit arrival-time parameter and three level-delay parameters.

The procedure repeatedly takes the three earliest remaining shift bits. It compares the estimated finish time of a fused three-bit level, a fused two-bit level and a single level, and keeps the fastest choice. The bits in one level may therefore be non-adjacent. Because logical shifts in one direction compose by adding their amounts, every grouping gives the same result. Only the depth and fan-in of the logic change.

Top module: `mshift_barrel`

## Requirements
- R1: data_o equals data_i shifted by shamt_i positions, toward bit WIDTH-1 when LEFT=1 and toward bit 0 when LEFT=0, truncated to WIDTH bits.
- R2: With shamt_i equal to 0, data_o equals data_i bit for bit.
- R3: The shamt_i vacated positions are zero: the lowest shamt_i bits for LEFT=1, the highest shamt_i bits for LEFT=0, even when data_i is all ones.
- R4: Bits moved past the word edge are discarded, so data_o never has more set bits than data_i.
- R5: For any ARRIVAL and DEL1/DEL2/DEL3 setting, the output is identical to R1. This covers groupings made of three-bit, two-bit and single levels.
- R6: A level may fuse shift bits that are not adjacent, and the result still obeys R1. One example is bits 1 and 3 fused first when they arrive earliest.
- R7: For WIDTH=4, LEFT=1 and shamt_i=2'b01, input bits {x3,x2,x1,x0} produce {x2,x1,x0,0}.
- R8: At the largest shift amount WIDTH-1, at most one bit of data_o can be set. That bit is data_i[0] moved to bit WIDTH-1 (left), or data_i[WIDTH-1] moved to bit 0 (right).
- R9: An all-zero data_i gives an all-zero data_o for every shift amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Word to be shifted |
| shamt_i | input | log2(WIDTH) | Shift distance, unsigned |
| data_o | output | WIDTH | Shifted word with zero fill |

## Verification
Five instances are built with different widths, directions and arrival profiles. Among them, the fused-level plans include a leading three-bit level, a non-adjacent two-bit pair, and a layout of only two-bit levels. Each instance is compared with a behavioural shift for every shift amount. A wrong offset sum inside a fused level would corrupt only the shift amounts that set several of that level's bits. A swapped select bit would exchange two non-adjacent distances. A missing zero fill would leak ones into the vacated edge when the input is all ones. The maximum shift and the zero input are driven on every instance, and the 4-bit example is checked literally.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

    localparam int MAX_SW = 6;
    localparam int TW     = 8;

    typedef enum logic [1:0] {
        LV_NONE  = 2'd0,
        LV_ONE   = 2'd1,
        LV_TWO   = 2'd2,
        LV_THREE = 2'd3
    } lvl_kind_e;

    typedef struct packed {
        lvl_kind_e   kind;
        logic [2:0]  b2;
        logic [2:0]  b1;
        logic [2:0]  b0;
    } lvl_t;

    typedef lvl_t [MAX_SW-1:0] plan_t;

    function automatic int arr_of(logic [MAX_SW*TW-1:0] a, int b);
        return int'(a[b*TW +: TW]);
    endfunction

    function automatic int imax(int x, int y);
        return (x > y) ? x : y;
    endfunction

    // earliest unused bit; ties go to the lower index
    function automatic int earliest(logic [MAX_SW*TW-1:0] a, int sw,
                                    logic [MAX_SW-1:0] used);
        int best;
        best = -1;
        for (int i = 0; i < MAX_SW; i++) begin
            if (i < sw && !used[i]) begin
                if (best < 0) best = i;
                else if (arr_of(a, i) < arr_of(a, best)) best = i;
            end
        end
        return best;
    endfunction

    function automatic plan_t build_plan(int sw, logic [MAX_SW*TW-1:0] a,
                                         int d1, int d2, int d3);
        plan_t             p;
        logic [MAX_SW-1:0] used;
        logic [MAX_SW-1:0] tmp;
        int                rem, lv, i, j, k;
        int                s1, s2, s3, du, tr;
        p    = '0;
        used = '0;
        rem  = sw;
        lv   = 0;
        for (int it = 0; it < MAX_SW; it++) begin
            if (rem > 0) begin
                i   = earliest(a, sw, used);
                tmp = used;
                tmp[i] = 1'b1;
                j = (rem >= 2) ? earliest(a, sw, tmp) : -1;
                if (j >= 0) tmp[j] = 1'b1;
                k = (rem >= 3) ? earliest(a, sw, tmp) : -1;
                s1 = arr_of(a, i) + d1;
                s2 = imax(s1, (j >= 0) ? arr_of(a, j) : 0) + d1;
                s3 = imax(s2, (k >= 0) ? arr_of(a, k) : 0) + d1;
                du = ((j >= 0) ? arr_of(a, j) : 0) + d2;
                tr = ((k >= 0) ? arr_of(a, k) : 0) + d3;
                if (k >= 0 && tr < s3 && (2 * tr) < (2 * du + d1)) begin
                    p[lv].kind = LV_THREE;
                    p[lv].b0   = 3'(i);
                    p[lv].b1   = 3'(j);
                    p[lv].b2   = 3'(k);
                    used[i] = 1'b1; used[j] = 1'b1; used[k] = 1'b1;
                    rem = rem - 3;
                end else if (j >= 0 && du < s2) begin
                    p[lv].kind = LV_TWO;
                    p[lv].b0   = 3'(i);
                    p[lv].b1   = 3'(j);
                    used[i] = 1'b1; used[j] = 1'b1;
                    rem = rem - 2;
                end else begin
                    p[lv].kind = LV_ONE;
                    p[lv].b0   = 3'(i);
                    used[i] = 1'b1;
                    rem = rem - 1;
                end
                lv = lv + 1;
            end
        end
        return p;
    endfunction

    function automatic int plan_levels(plan_t p);
        int n;
        n = 0;
        for (int l = 0; l < MAX_SW; l++)
            if (p[l].kind != LV_NONE) n++;
        return n;
    endfunction

    function automatic int level_bit(lvl_t l, int t);
        case (t)
            0:       return int'(l.b0);
            1:       return int'(l.b1);
            default: return int'(l.b2);
        endcase
    endfunction

endpackage

// File: rtl/mshift_cand.sv
module mshift_cand #(
    parameter int WIDTH = 16,
    parameter bit LEFT  = 1'b1,
    parameter int OFS   = 0
) (
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);
    // constant-distance copy: pure wiring with zero fill
    if (LEFT) begin : g_left
        assign data_o = data_i << OFS;
    end else begin : g_right
        assign data_o = data_i >> OFS;
    end
endmodule

// File: rtl/mshift_level.sv
module mshift_level #(
    parameter int WIDTH = 16,
    parameter bit LEFT  = 1'b1,
    parameter int NSEL  = 1,
    parameter int OFF0  = 1,
    parameter int OFF1  = 0,
    parameter int OFF2  = 0
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [NSEL-1:0]  sel_i,
    output logic [WIDTH-1:0] data_o
);
    localparam int NCAND = 1 << NSEL;

    logic [WIDTH-1:0] cand [NCAND];

    // candidate p applies the offsets whose select bits are set in p
    for (genvar p = 0; p < NCAND; p++) begin : g_cand
        localparam int OFS = (((p & 1) != 0) ? OFF0 : 0)
                           + (((p & 2) != 0) ? OFF1 : 0)
                           + (((p & 4) != 0) ? OFF2 : 0);
        mshift_cand #(
            .WIDTH (WIDTH),
            .LEFT  (LEFT),
            .OFS   (OFS)
        ) u_cand (
            .data_i (data_i),
            .data_o (cand[p])
        );
    end

    assign data_o = cand[sel_i];
endmodule

// File: rtl/mshift_barrel.sv
module mshift_barrel
    import mshift_pkg::*;
#(
    parameter int                   WIDTH   = 16,
    parameter bit                   LEFT    = 1'b1,
    parameter logic [MAX_SW*TW-1:0] ARRIVAL = '0,
    parameter int                   DEL1    = 10,
    parameter int                   DEL2    = 14,
    parameter int                   DEL3    = 18
) (
    input  logic [WIDTH-1:0]         data_i,
    input  logic [$clog2(WIDTH)-1:0] shamt_i,
    output logic [WIDTH-1:0]         data_o
);
    localparam int    SW   = $clog2(WIDTH);
    localparam plan_t PLAN = build_plan(SW, ARRIVAL, DEL1, DEL2, DEL3);
    localparam int    NLEV = plan_levels(PLAN);

    logic [WIDTH-1:0] lvl_data [NLEV+1];

    assign lvl_data[0] = data_i;

    for (genvar g = 0; g < NLEV; g++) begin : g_lvl
        localparam lvl_t LV   = PLAN[g];
        localparam int   NSEL = int'(LV.kind);
        localparam int   BI0  = level_bit(LV, 0);
        localparam int   BI1  = level_bit(LV, 1);
        localparam int   BI2  = level_bit(LV, 2);

        logic [NSEL-1:0] sel;

        for (genvar t = 0; t < NSEL; t++) begin : g_sel
            localparam int BT = (t == 0) ? BI0 : ((t == 1) ? BI1 : BI2);
            assign sel[t] = shamt_i[BT];
        end

        mshift_level #(
            .WIDTH (WIDTH),
            .LEFT  (LEFT),
            .NSEL  (NSEL),
            .OFF0  (1 << BI0),
            .OFF1  ((NSEL > 1) ? (1 << BI1) : 0),
            .OFF2  ((NSEL > 2) ? (1 << BI2) : 0)
        ) u_level (
            .data_i (lvl_data[g]),
            .sel_i  (sel),
            .data_o (lvl_data[g+1])
        );
    end

    assign data_o = lvl_data[NLEV];
endmodule

// File: rtl/mshift_barrel_chk.sv
module mshift_barrel_chk #(
    parameter int WIDTH = 16,
    parameter bit LEFT  = 1'b1
) (
    input logic [WIDTH-1:0]         data_i,
    input logic [$clog2(WIDTH)-1:0] shamt_i,
    input logic [WIDTH-1:0]         data_o
);
    logic [WIDTH-1:0] vac;
    logic [WIDTH-1:0] want;

    always_comb begin
        for (int q = 0; q < WIDTH; q++)
            vac[q] = LEFT ? (q < int'(shamt_i)) : (q >= WIDTH - int'(shamt_i));
        want = LEFT ? (data_i << shamt_i) : (data_i >> shamt_i);

        a_r1_match: assert (data_o == want);
        if (shamt_i == '0)
            a_r2_zero_shift: assert (data_o == data_i);
        a_r3_fill_zero: assert ((data_o & vac) == '0);
        a_r4_no_gain: assert ($countones(data_o) <= $countones(data_i));
        if (int'(shamt_i) == WIDTH - 1)
            a_r8_single_bit: assert ($onehot0(data_o));
        if (data_i == '0)
            a_r9_zero_in: assert (data_o == '0);
    end
endmodule

bind mshift_barrel mshift_barrel_chk #(
    .WIDTH (WIDTH),
    .LEFT  (LEFT)
) u_chk (
    .data_i  (data_i),
    .shamt_i (shamt_i),
    .data_o  (data_o)
);

// File: tb/mshift_barrel_bench.sv
module mshift_barrel_bench;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] din = '0;
    logic [5:0]  sh  = '0;

    logic [15:0] o16l, o16r;
    logic [3:0]  o4;
    logic [31:0] o32;
    logic [63:0] o64;

    // all arrivals equal: three-bit level then a single level
    mshift_barrel #(.WIDTH(16), .LEFT(1'b1)) u_mshift_barrel (
        .data_i(din[15:0]), .shamt_i(sh[3:0]), .data_o(o16l));

    // bit1 and bit3 earliest: non-adjacent two-bit level first
    mshift_barrel #(.WIDTH(16), .LEFT(1'b0),
        .ARRIVAL({8'd0, 8'd0, 8'd5, 8'd12, 8'd0, 8'd30})) u_mshift_barrel_rt (
        .data_i(din[15:0]), .shamt_i(sh[3:0]), .data_o(o16r));

    mshift_barrel #(.WIDTH(4), .LEFT(1'b1)) u_mshift_barrel_w4 (
        .data_i(din[3:0]), .shamt_i(sh[1:0]), .data_o(o4));

    mshift_barrel #(.WIDTH(32), .LEFT(1'b1),
        .ARRIVAL({8'd0, 8'd3, 8'd20, 8'd9, 8'd60, 8'd0})) u_mshift_barrel_w32 (
        .data_i(din[31:0]), .shamt_i(sh[4:0]), .data_o(o32));

    mshift_barrel #(.WIDTH(64), .LEFT(1'b0),
        .ARRIVAL({8'd1, 8'd50, 8'd4, 8'd2, 8'd40, 8'd0})) u_mshift_barrel_w64 (
        .data_i(din), .shamt_i(sh), .data_o(o64));

    function automatic logic [63:0] ref_sh(logic [63:0] d, int s, int w, bit left);
        logic [63:0] m;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        d = d & m;
        return (left ? (d << s) : (d >> s)) & m;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (data %h shift %0d)",
                     req, got, exp, din, sh);
        end
    endtask

    function automatic string tag(int s, int w, logic [63:0] d, string dflt);
        logic [63:0] m;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        if ((d & m) == '0)    return "R9";
        if ((d & m) == m)     return "R3";
        if (s == 0)           return "R2";
        if (s == w - 1)       return "R8";
        return dflt;
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        // R7: literal 4-bit example, x3..x0 = 1,0,1,1 shifted by one
        @(negedge clk);
        din = 64'hB;
        sh  = 6'd1;
        #1;
        check("R7", {60'd0, o4}, 64'h6);

        for (int s = 0; s < 64; s++) begin
            for (int r = 0; r < 24; r++) begin
                logic [63:0] d;
                case (r)
                    0:       d = '0;
                    1:       d = '1;
                    2:       d = 64'h1;
                    3:       d = 64'h8000_0000_0000_0000;
                    default: d = {$urandom, $urandom};
                endcase
                @(negedge clk);
                din = d;
                sh  = 6'(s);
                #1;
                // R1: main left path
                check(tag(s % 16, 16, d, "R1"), {48'd0, o16l},
                      ref_sh(d, s % 16, 16, 1'b1));
                // R6: non-adjacent fused pair on a right shifter
                check(tag(s % 16, 16, d, "R6"), {48'd0, o16r},
                      ref_sh(d, s % 16, 16, 1'b0));
                // R5: plans made of other groupings
                check(tag(s % 4, 4, d, "R5"), {60'd0, o4},
                      ref_sh(d, s % 4, 4, 1'b1));
                check(tag(s % 32, 32, d, "R5"), {32'd0, o32},
                      ref_sh(d, s % 32, 32, 1'b1));
                check(tag(s, 64, d, "R5"), o64, ref_sh(d, s, 64, 1'b0));
                // R4: set-bit count never grows
                if ($countones(o64) > $countones(d)) begin
                    n_chk++; n_fail++;
                    $display("FAIL R4: got %0d ones expected at most %0d",
                             $countones(o64), $countones(d));
                end else begin
                    n_chk++;
                end
            end
        end

        // R8: single surviving bit at the maximum shift
        @(negedge clk);
        din = '1;
        sh  = 6'd63;
        #1;
        check("R8", o64, 64'h1);
        check("R8", {48'd0, o16l}, 64'h8000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule